// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block sequences one DMA channel. It moves 32-bit words between a peripheral-side port and a memory-side port. Each side has a read channel and a write channel, and each channel is a plain valid/ready word handshake. Address generation and bus protocol timing sit outside the block. Software writes a control word and reads it back, reads a status word, and acknowledges the end-of-count flag with a write-one-to-clear strobe.

The channel holds at most one word in flight: it fetches a word from the source side, then delivers that word to the sink side. Pacing comes from one of 31 peripheral request lines, chosen by a 5-bit selector. Selector value 31 parks the channel so that software can read the remaining count.

There are two modes:
- **One-shot:** the channel runs a single count and then stops.
- **Continuous:** the count describes half a buffer. The channel reloads the count and keeps running, flipping a ping-pong flag at every half.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the status and control read-backs are zero, every ready and valid the block drives is low, and `irq` is low.
- R2: Control word fields:
  - enable is bit 31, end-of-count interrupt enable is bit 30, hold is bit 29, direction is bit 28, one-shot is bit 27, flow control is bit 21.
  - Request select occupies bits 20:16 and the word count occupies bits 15:2.
  - All other bits read back as 0.
- R3: Status word fields:
  - busy is bit 31, end-of-count pending is bit 30, halt is bit 29, ping-pong is bit 28.
  - The remaining word count occupies bits 15:2.
  - All other bits read 0.
- R4: A programmed count of C moves C+1 words. In one-shot mode, after the last word the channel drops busy, clears the enable bit of the control word, and sets end-of-count.
- R5: In continuous mode, after C+1 words the channel sets end-of-count, reloads the count from the control word, and keeps running without software action.
- R6: The ping-pong flag toggles each time a count reaches completion and is 0 after every start.
- R7: Direction selects the data path:
  - Direction 0 fetches from the peripheral read port and delivers to the memory write port.
  - Direction 1 fetches from the memory read port and delivers to the peripheral write port.
  - Data passes unchanged, and the unused side's ready and valid stay low.
- R8: With flow control set, a word is fetched only in cycles where the selected request line is high. With flow control clear, the request lines are ignored.
- R9: Request select 31 stops all new fetches and sets halt. The remaining count holds its value while the channel stays busy.
- R10: The hold bit freezes fetching and sets halt in the same way as request select 31.
- R11: Clearing enable lets an in-flight word finish and then drops busy. A control write with enable set while idle restarts the channel with the count reloaded from that write.
- R12: A status acknowledge with the end-of-count bit set clears the pending flag, and an acknowledge with that bit clear has no effect. A completion in the same cycle as an acknowledge leaves the flag set.
- R13: `irq` is high exactly when end-of-count is pending and the interrupt enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read-back |
| stat_we | input | 1 | Status acknowledge strobe |
| stat_eoc_w1c | input | 1 | Value written to the end-of-count bit (1 clears) |
| stat_rdata | output | 32 | Status word |
| dreq | input | 32 | Peripheral request lines, indexed by request select (line 31 unused) |
| irq | output | 1 | End-of-count interrupt |
| per_rd_valid | input | 1 | Peripheral read word valid |
| per_rd_ready | output | 1 | Peripheral read word accepted |
| per_rd_data | input | 32 | Peripheral read word |
| per_wr_valid | output | 1 | Peripheral write word valid |
| per_wr_ready | input | 1 | Peripheral write word accepted |
| per_wr_data | output | 32 | Peripheral write word |
| mem_rd_valid | input | 1 | Memory read word valid |
| mem_rd_ready | output | 1 | Memory read word accepted |
| mem_rd_data | input | 32 | Memory read word |
| mem_wr_valid | output | 1 | Memory write word valid |
| mem_wr_ready | input | 1 | Memory write word accepted |
| mem_wr_data | output | 32 | Memory write word |

## Verification
The assertions assume that software does not rewrite the control word in the same cycle as a one-shot completion, and that a status acknowledge does not coincide with a word delivery whenever the pending flag must be seen cleared. The bench keeps control writes to isolated cycles. Random acknowledges may land on a completion cycle, because the reference model resolves that collision in favour of the set. Handshake valids, readies and request lines are otherwise free-running random, and the assertions place no ordering rule on them.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [31:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  input  logic          stat_we,
  input  logic          stat_eoc_w1c,
  output logic [31:0]   stat_rdata,
  input  logic [31:0]   dreq,
  output logic          irq,
  input  logic          per_rd_valid,
  output logic          per_rd_ready,
  input  logic [DW-1:0] per_rd_data,
  output logic          per_wr_valid,
  input  logic          per_wr_ready,
  output logic [DW-1:0] per_wr_data,
  input  logic          mem_rd_valid,
  output logic          mem_rd_ready,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [DW-1:0] mem_wr_data
);
  localparam int CW = 14;
  localparam logic [31:0] CFG_KEEP = 32'hF83F_FFFC;
  localparam logic [4:0]  SEL_PARK = 5'd31;

  logic [31:0]   ctl;
  logic [CW-1:0] cnt;
  logic [DW-1:0] word;
  logic          busy, full, eoc, pp;

  wire          en    = ctl[31];
  wire          hold  = ctl[29];
  wire          dir   = ctl[28];
  wire          once  = ctl[27];
  wire          flow  = ctl[21];
  wire [4:0]    sel   = ctl[20:16];
  wire [CW-1:0] wc    = ctl[15:2];

  wire frozen = hold | (sel == SEL_PARK);
  wire go     = busy & ~full & en & ~frozen & (~flow | dreq[sel]);
  wire src_v  = dir ? mem_rd_valid : per_rd_valid;
  wire snk_r  = dir ? per_wr_ready : mem_wr_ready;
  wire take   = go & src_v;
  wire drain  = full & snk_r;
  wire last   = (cnt == '0);
  wire start  = cfg_we & cfg_wdata[31] & ~busy;

  assign per_rd_ready = go & ~dir;
  assign mem_rd_ready = go & dir;
  assign per_wr_valid = full & dir;
  assign mem_wr_valid = full & ~dir;
  assign per_wr_data  = word;
  assign mem_wr_data  = word;
  assign cfg_rdata    = ctl;
  assign stat_rdata   = {busy, eoc, busy & frozen, pp, 12'd0, cnt, 2'b00};
  assign irq          = eoc & ctl[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl  <= '0;
      cnt  <= '0;
      word <= '0;
      busy <= 1'b0;
      full <= 1'b0;
      eoc  <= 1'b0;
      pp   <= 1'b0;
    end else begin
      if (take) begin
        full <= 1'b1;
        word <= dir ? mem_rd_data : per_rd_data;
      end
      if (busy & ~full & ~en) busy <= 1'b0;
      if (drain) begin
        full <= 1'b0;
        if (last) begin
          pp <= ~pp;
          if (once) busy <= 1'b0;
          else      cnt  <= wc;
        end else begin
          cnt <= cnt - 1'b1;
        end
        if (~en) busy <= 1'b0;
      end
      if (drain & last)                 eoc <= 1'b1;
      else if (stat_we & stat_eoc_w1c)  eoc <= 1'b0;
      if (cfg_we)                       ctl <= cfg_wdata & CFG_KEEP;
      else if (drain & last & once)     ctl[31] <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        full <= 1'b0;
        cnt  <= cfg_wdata[15:2];
        pp   <= 1'b0;
      end
    end
  end
endmodule

module dma_chan_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        stat_we,
  input logic        stat_eoc_w1c,
  input logic [31:0] stat_rdata,
  input logic        irq,
  input logic        per_rd_ready,
  input logic        mem_rd_ready,
  input logic        per_wr_valid,
  input logic        per_wr_ready,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready
);
  wire sink_v  = per_wr_valid | mem_wr_valid;
  wire sink_hs = (per_wr_valid & per_wr_ready) | (mem_wr_valid & mem_wr_ready);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[31] |-> !sink_v && !per_rd_ready && !mem_rd_ready);

  assert_oneshot_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sink_hs && stat_rdata[15:2] == 14'd0 && cfg_rdata[27] && !cfg_we
    |=> !stat_rdata[31] && !cfg_rdata[31] && stat_rdata[30]);

  assert_start_pp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[31] && !stat_rdata[31] |=> stat_rdata[31] && !stat_rdata[28]);

  assert_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(per_rd_ready && mem_rd_ready) && !(per_wr_valid && mem_wr_valid));

  assert_no_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[29] |-> !per_rd_ready && !mem_rd_ready);

  assert_frozen_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[29] && !sink_v && !cfg_we |=> $stable(stat_rdata[15:2]));

  assert_ack_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we && stat_eoc_w1c && !sink_v |=> !stat_rdata[30]);

  assert_irq_source_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_rdata[30] && cfg_rdata[30]);
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .stat_we(stat_we), .stat_eoc_w1c(stat_eoc_w1c),
  .stat_rdata(stat_rdata), .irq(irq), .per_rd_ready(per_rd_ready),
  .mem_rd_ready(mem_rd_ready), .per_wr_valid(per_wr_valid),
  .per_wr_ready(per_wr_ready), .mem_wr_valid(mem_wr_valid),
  .mem_wr_ready(mem_wr_ready)
);

// File: tb/tb_dma_chan_seq.sv
`timescale 1ns/1ps
module tb_dma_chan_seq;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        rst_n = 0;
  logic        cfg_we = 0, stat_we = 0, stat_eoc_w1c = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, stat_rdata, dreq = 0;
  logic        irq;
  logic        per_rd_valid = 0, per_rd_ready, per_wr_valid, per_wr_ready = 0;
  logic        mem_rd_valid = 0, mem_rd_ready, mem_wr_valid, mem_wr_ready = 0;
  logic [31:0] per_rd_data = 0, per_wr_data, mem_rd_data = 0, mem_wr_data;

  dma_chan_seq dut (.*);

  localparam logic [31:0] KEEP = 32'hF83F_FFFC;
  int checks = 0, fails = 0, words = 0;
  bit done = 0, rnd = 0, rnd_req = 0;

  logic [31:0] m_ctl = 0, m_word = 0;
  logic [13:0] m_cnt = 0;
  bit m_busy = 0, m_full = 0, m_eoc = 0, m_pp = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit cw, logic [31:0] cd, bit sw, bit sd);
    logic [4:0] sel;
    bit go, dir, sv, sr, o_busy, o_full;
    logic [13:0] o_cnt;
    logic [31:0] o_ctl;
    @(negedge clk);
    cfg_we = cw; cfg_wdata = cd; stat_we = sw; stat_eoc_w1c = sd;
    if (rnd) begin
      per_rd_valid = $urandom_range(0, 3) != 0; mem_rd_valid = $urandom_range(0, 3) != 0;
      per_wr_ready = $urandom_range(0, 2) != 0; mem_wr_ready = $urandom_range(0, 2) != 0;
      per_rd_data = $urandom; mem_rd_data = $urandom;
    end
    if (rnd_req) dreq = $urandom;
    #1;
    sel = m_ctl[20:16];
    dir = m_ctl[28];
    go = m_busy && !m_full && m_ctl[31] && !m_ctl[29] && sel != 5'd31 &&
         (!m_ctl[21] || dreq[sel]);
    chk("R7 per_rd_ready", per_rd_ready, go && !dir);
    chk("R7 mem_rd_ready", mem_rd_ready, go && dir);
    chk("R7 per_wr_valid", per_wr_valid, m_full && dir);
    chk("R7 mem_wr_valid", mem_wr_valid, m_full && !dir);
    if (m_full) chk("R7 data", dir ? per_wr_data : mem_wr_data, m_word);
    chk("R3 status word", stat_rdata,
        {m_busy, m_eoc, m_busy && (m_ctl[29] || sel == 5'd31), m_pp, 12'd0, m_cnt, 2'b00});
    chk("R2 control read-back", cfg_rdata, m_ctl);
    chk("R13 irq", irq, m_eoc && m_ctl[30]);
    sv = dir ? mem_rd_valid : per_rd_valid;
    sr = dir ? per_wr_ready : mem_wr_ready;
    o_busy = m_busy; o_full = m_full; o_cnt = m_cnt; o_ctl = m_ctl;
    if (go && sv) begin m_full = 1; m_word = dir ? mem_rd_data : per_rd_data; end
    if (o_busy && !o_full && !o_ctl[31]) m_busy = 0;
    if (o_full && sr) begin
      m_full = 0; words++;
      if (o_cnt == 0) begin
        m_pp = !m_pp; m_eoc = 1;
        if (o_ctl[27]) begin m_busy = 0; if (!cw) m_ctl[31] = 0; end
        else m_cnt = o_ctl[15:2];
      end else begin
        m_cnt = o_cnt - 1;
        if (sw && sd) m_eoc = 0;
      end
      if (!o_ctl[31]) m_busy = 0;
    end else if (sw && sd) m_eoc = 0;
    if (cw) begin
      m_ctl = cd & KEEP;
      if (cd[31] && !o_busy) begin m_busy = 1; m_full = 0; m_cnt = cd[15:2]; m_pp = 0; end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    logic [13:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0);
    chk("R1 reset status", stat_rdata, 0);
    chk("R1 reset irq", irq, 0);

    // one-shot, peripheral to memory, 4 words, stray bits set
    rnd = 1;
    a = 32'hC800_000C | 32'h0040_0003;
    step(1, a, 0, 0);
    for (int i = 0; i < 300 && m_busy; i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R4 one-shot words moved", words, 4);
    chk("R4 busy dropped", stat_rdata[31], 0);
    chk("R4 end-of-count set", stat_rdata[30], 1);
    chk("R6 ping-pong after one count", stat_rdata[28], 1);
    chk("R13 irq raised", irq, 1);
    chk("R2 masked read-back", cfg_rdata, a & KEEP & 32'h7FFF_FFFF);

    step(0, 0, 1, 0); step(0, 0, 0, 0);
    chk("R12 ack without bit keeps flag", stat_rdata[30], 1);
    step(0, 0, 1, 1); step(0, 0, 0, 0);
    chk("R12 ack clears flag", stat_rdata[30], 0);
    chk("R13 irq follows flag", irq, 0);

    // continuous, memory to peripheral, flow on line 5, count 2
    rnd_req = 1; words = 0;
    b = 32'h9025_0008;
    step(1, b, 0, 0);
    for (int i = 0; i < 80; i++) step(0, 0, $urandom_range(0, 7) == 0, 1);
    chk("R5 still busy after several halves", stat_rdata[31], 1);
    chk("R5 words beyond one half", words > 3, 1);
    chk("R13 irq masked by enable bit", irq, 0);

    step(1, b | 32'h001F_0000, 0, 0);
    idle(4);
    held = stat_rdata[15:2];
    idle(20);
    chk("R9 count held while parked", stat_rdata[15:2], held);
    chk("R9 halt reported", stat_rdata[29], 1);

    step(1, b | 32'h2000_0000, 0, 0);
    idle(4);
    held = stat_rdata[15:2];
    idle(20);
    chk("R10 count held under hold", stat_rdata[15:2], held);
    chk("R10 halt reported", stat_rdata[29], 1);

    step(1, b, 0, 0);
    rnd_req = 0; dreq = 0;
    idle(4);
    held = stat_rdata[15:2];
    idle(20);
    chk("R8 no progress without request", stat_rdata[15:2], held);
    rnd_req = 1;
    idle(20);

    step(1, b & 32'h7FFF_FFFF, 0, 0);
    for (int i = 0; i < 40 && m_busy; i++) step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    chk("R11 busy dropped after disable", stat_rdata[31], 0);
    step(1, 32'h8020_0014, 0, 0);
    step(0, 0, 0, 0);
    chk("R11 count reloaded on restart", stat_rdata[15:2], 5);
    chk("R6 ping-pong zero on start", stat_rdata[28], 0);
    idle(200);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule